// File: doc/BRIEF.md
# IDE Programmed-I/O Cycle Timer

This block turns host I/O requests from a 32-bit local bus into timed 16-bit cycles on an IDE drive cable. It decodes the request address against up to four drive channel bases, each of which can be switched on or off. A decoded request is claimed on the local bus in the same cycle, so an older controller at the same address stays silent. The block then drives the channel index, the register offset, one of the two chip selects, the read or write strobe and the write data. It uses a programmed number of clocks for address setup, for the strobe, and for recovery after the strobe. When the cycle has ended it answers the host with a one-clock ready.

Each channel holds two drives. The block remembers which drive was last selected by a write to that channel's drive/head register. A select vector then maps every channel/drive pair onto one of two independent timing sets. A 32-bit access to the data register becomes two 16-bit strobes, and the register at control-block offset 7 is left to the floppy controller that shares it.

Top module: `ide_pio_timer`

## Requirements
- R1: A request whose address is in the command block (base to base+7) or equals control address base+0x206 of an enabled channel raises `host_claim` in the same cycle as `host_req`. Default bases are channel 0 = 0x1F0, 1 = 0x170, 2 = 0x1E8, 3 = 0x168.
- R2: A request to a disabled channel, or to an address that no channel decodes, raises no claim, drives no strobe and gives no ready.
- R3: Control address base+0x207 is never claimed, so the register that is shared with the floppy controller passes through untouched.
- R4: A cycle holds its chip select with both strobes high for the setup count. It then holds its strobe low for the read or write length, then holds both strobes high for the recovery count. A programmed count of 0 acts as 1.
- R5: A 32-bit access to command offset 0 makes two strobes. The low word (`host_wdata[15:0]`) goes first and the high word second. A full recovery period separates the two strobes, and no second setup period is inserted.
- R6: A 16-bit access to offset 0 is a single 16-bit strobe. Any other offset is a single byte cycle whose read result is `{24'b0, ide_dd_in[7:0]}`. A split read returns `{second word, first word}`. `ide_dd_oe` is high from setup through recovery of a write only.
- R7: The timing set of a cycle is `drv_tsel[2*channel + dev]`, where set 0 or 1 selects an index into the `set_*` ports. `dev` is bit 4 of the most recent write to command offset 6 of that channel, and it is 0 after reset. That write itself still uses the earlier selection.
- R8: `host_rdy` is high for exactly one clock, in the cycle after the final recovery period. Read data is valid in that cycle.
- R9: The command block drives `ide_cs0_n` low and the control register drives `ide_cs1_n` low, only from setup through recovery. `ide_a` carries address bits 2:0 and `ide_chan` carries the channel index. After reset no select and no strobe is active.
- R10: The read and write strobes are never low together, and address and channel hold steady while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-clock I/O request, issued only while the block is idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wide | input | 1 | 32-bit access when set |
| host_addr | input | 16 | I/O address |
| host_wdata | input | 32 | Write data |
| host_claim | output | 1 | Request decoded and taken by this block |
| host_rdy | output | 1 | One-clock completion |
| host_rdata | output | 32 | Read result, valid with host_rdy |
| base_en | input | NBASE (4) | Per-channel enable |
| drv_tsel | input | 2*NBASE (8) | Timing set of each channel/drive pair |
| set_setup | input | 2*TW (8) | Setup count, per set |
| set_rdlen | input | 2*TW (8) | Read strobe length, per set |
| set_wrlen | input | 2*TW (8) | Write strobe length, per set |
| set_recov | input | 2*TW (8) | Recovery count, per set |
| ide_chan | output | CW (2) | Channel index of the current cycle |
| ide_cs0_n | output | 1 | Command block select, active low |
| ide_cs1_n | output | 1 | Control block select, active low |
| ide_a | output | 3 | Register offset |
| ide_dior_n | output | 1 | Read strobe, active low |
| ide_diow_n | output | 1 | Write strobe, active low |
| ide_dd_out | output | 16 | Drive write data |
| ide_dd_oe | output | 1 | Write data enable |
| ide_dd_in | input | 16 | Drive read data |

## Verification
The claim depends only on the request and the decode, so it is checked 1 ns after the request is driven, in the same cycle. The cable signals come from registered state. For an access taken at edge k, the expected cable value for each of the cycles that follow is placed in a queue. There are S setup entries, A strobe entries and R recovery entries, plus another A and R for a split access, then one ready entry. Each entry is compared at the falling edge that ends its cycle. Read data is captured on the edge that ends the strobe, so it is compared in the ready cycle alongside `host_rdy`. Idle and unclaimed periods are compared against the quiet bus every cycle.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_ACTIVE,
      ST_RECOV,
      ST_DONE
   } pio_st_t;
endpackage

// File: rtl/ide_addr_decode.sv
module ide_addr_decode #(
   parameter int NBASE = 4,
   parameter int CW    = 2,
   parameter logic [NBASE*16-1:0] BASES = {16'h0168, 16'h01E8, 16'h0170, 16'h01F0}
) (
   input  logic [15:0]      addr,
   input  logic [NBASE-1:0] base_en,
   output logic             hit,
   output logic [CW-1:0]    chan,
   output logic             is_ctl,
   output logic [2:0]       off
);
   localparam logic [15:0] CTL_OFS = 16'h0206;

   logic [NBASE-1:0] cmd_hit;
   logic [NBASE-1:0] ctl_hit;

   for (genvar g = 0; g < NBASE; g++) begin : g_base
      assign cmd_hit[g] = base_en[g] && (addr[15:3] == BASES[g*16+3 +: 13]);
      assign ctl_hit[g] = base_en[g] && (addr == BASES[g*16 +: 16] + CTL_OFS);
   end

   always_comb begin
      hit    = 1'b0;
      chan   = '0;
      is_ctl = 1'b0;
      for (int i = NBASE - 1; i >= 0; i--) begin
         if (cmd_hit[i] || ctl_hit[i]) begin
            hit    = 1'b1;
            chan   = CW'(i);
            is_ctl = ctl_hit[i];
         end
      end
   end

   assign off = addr[2:0];
endmodule

// File: rtl/ide_timing_sel.sv
module ide_timing_sel #(
   parameter int NBASE = 4,
   parameter int TW    = 4,
   parameter int CW    = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd_en,
   input  logic [CW-1:0]        upd_chan,
   input  logic                 upd_dev,
   input  logic [CW-1:0]        look_chan,
   input  logic                 look_wr,
   input  logic [2*NBASE-1:0]   drv_tsel,
   input  logic [1:0][TW-1:0]   set_setup,
   input  logic [1:0][TW-1:0]   set_rdlen,
   input  logic [1:0][TW-1:0]   set_wrlen,
   input  logic [1:0][TW-1:0]   set_recov,
   output logic [TW-1:0]        tm_setup,
   output logic [TW-1:0]        tm_act,
   output logic [TW-1:0]        tm_rec
);
   logic [NBASE-1:0] dev_q;
   logic             sidx;

   for (genvar g = 0; g < NBASE; g++) begin : g_dev
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dev_q[g] <= 1'b0;
         else if (upd_en && (upd_chan == CW'(g)))
            dev_q[g] <= upd_dev;
      end
   end

   always_comb begin
      sidx     = drv_tsel[{look_chan, dev_q[look_chan]}];
      tm_setup = set_setup[sidx];
      tm_act   = look_wr ? set_wrlen[sidx] : set_rdlen[sidx];
      tm_rec   = set_recov[sidx];
   end

   AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(dev_q)); // R7
endmodule

// File: rtl/ide_cycle_fsm.sv
module ide_cycle_fsm
   import ide_pio_pkg::*;
#(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          in_wr,
   input  logic          in_split,
   input  logic          in_byte,
   input  logic [TW-1:0] in_setup,
   input  logic [TW-1:0] in_act,
   input  logic [TW-1:0] in_rec,
   input  logic [31:0]   in_wdata,
   input  logic [15:0]   dd_in,
   output logic          busy,
   output logic          bus_on,
   output logic          strobe,
   output logic          wr_q,
   output logic          rdy,
   output logic [31:0]   rdata,
   output logic [15:0]   dout
);
   pio_st_t       st;
   logic [TW-1:0] cnt;
   logic [TW-1:0] act_q;
   logic [TW-1:0] rec_q;
   logic          word_q;
   logic          split_q;
   logic          byte_q;
   logic [31:0]   wd_q;

   function automatic logic [TW-1:0] first_cnt(input logic [TW-1:0] n);
      return (n == '0) ? '0 : n - 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         act_q   <= '0;
         rec_q   <= '0;
         word_q  <= 1'b0;
         split_q <= 1'b0;
         byte_q  <= 1'b0;
         wr_q    <= 1'b0;
         wd_q    <= '0;
         rdata   <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st      <= ST_SETUP;
               cnt     <= first_cnt(in_setup);
               act_q   <= in_act;
               rec_q   <= in_rec;
               wr_q    <= in_wr;
               split_q <= in_split;
               byte_q  <= in_byte;
               wd_q    <= in_wdata;
               word_q  <= 1'b0;
               rdata   <= '0;
            end
            ST_SETUP: if (cnt == '0) begin
               st  <= ST_ACTIVE;
               cnt <= first_cnt(act_q);
            end else cnt <= cnt - 1'b1;
            ST_ACTIVE: if (cnt == '0) begin
               st  <= ST_RECOV;
               cnt <= first_cnt(rec_q);
               if (!wr_q) begin
                  if (word_q)      rdata[31:16] <= dd_in;
                  else if (byte_q) rdata[7:0]   <= dd_in[7:0];
                  else             rdata[15:0]  <= dd_in;
               end
            end else cnt <= cnt - 1'b1;
            ST_RECOV: if (cnt == '0) begin
               if (split_q && !word_q) begin
                  word_q <= 1'b1;
                  st     <= ST_ACTIVE;
                  cnt    <= first_cnt(act_q);
               end else st <= ST_DONE;
            end else cnt <= cnt - 1'b1;
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (st != ST_IDLE);
   assign bus_on = (st == ST_SETUP) || (st == ST_ACTIVE) || (st == ST_RECOV);
   assign strobe = (st == ST_ACTIVE);
   assign rdy    = (st == ST_DONE);
   assign dout   = word_q ? wd_q[31:16] : wd_q[15:0];

   AST_RDY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      rdy |=> !rdy); // R8
   AST_SPLIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_q) |-> ($past(st) == ST_RECOV) && split_q); // R5
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer #(
   parameter int NBASE = 4,
   parameter int TW    = 4,
   parameter logic [NBASE*16-1:0] BASES = {16'h0168, 16'h01E8, 16'h0170, 16'h01F0},
   localparam int CW   = (NBASE > 1) ? $clog2(NBASE) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 host_req,
   input  logic                 host_wr,
   input  logic                 host_wide,
   input  logic [15:0]          host_addr,
   input  logic [31:0]          host_wdata,
   output logic                 host_claim,
   output logic                 host_rdy,
   output logic [31:0]          host_rdata,
   input  logic [NBASE-1:0]     base_en,
   input  logic [2*NBASE-1:0]   drv_tsel,
   input  logic [1:0][TW-1:0]   set_setup,
   input  logic [1:0][TW-1:0]   set_rdlen,
   input  logic [1:0][TW-1:0]   set_wrlen,
   input  logic [1:0][TW-1:0]   set_recov,
   output logic [CW-1:0]        ide_chan,
   output logic                 ide_cs0_n,
   output logic                 ide_cs1_n,
   output logic [2:0]           ide_a,
   output logic                 ide_dior_n,
   output logic                 ide_diow_n,
   output logic [15:0]          ide_dd_out,
   output logic                 ide_dd_oe,
   input  logic [15:0]          ide_dd_in
);
   if (NBASE < 1 || NBASE > 4) begin : g_bad_nbase
      $error("NBASE must lie in 1..4");
   end
   if (TW < 1) begin : g_bad_tw
      $error("TW must be at least 1");
   end

   logic          dec_hit, dec_ctl;
   logic [CW-1:0] dec_chan;
   logic [2:0]    dec_off;
   logic          start, busy, bus_on, strobe, wr_q;
   logic          ctl_q;
   logic [TW-1:0] tm_setup, tm_act, tm_rec;

   ide_addr_decode #(.NBASE(NBASE), .CW(CW), .BASES(BASES)) u_dec (
      .addr(host_addr), .base_en(base_en), .hit(dec_hit),
      .chan(dec_chan), .is_ctl(dec_ctl), .off(dec_off));

   assign host_claim = host_req && dec_hit;
   assign start      = host_claim && !busy;

   ide_timing_sel #(.NBASE(NBASE), .TW(TW), .CW(CW)) u_sel (
      .clk(clk), .rst_n(rst_n),
      .upd_en(start && host_wr && !dec_ctl && (dec_off == 3'd6)),
      .upd_chan(dec_chan), .upd_dev(host_wdata[4]),
      .look_chan(dec_chan), .look_wr(host_wr), .drv_tsel(drv_tsel),
      .set_setup(set_setup), .set_rdlen(set_rdlen),
      .set_wrlen(set_wrlen), .set_recov(set_recov),
      .tm_setup(tm_setup), .tm_act(tm_act), .tm_rec(tm_rec));

   ide_cycle_fsm #(.TW(TW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .in_wr(host_wr),
      .in_split(!dec_ctl && (dec_off == 3'd0) && host_wide),
      .in_byte(dec_ctl || (dec_off != 3'd0)),
      .in_setup(tm_setup), .in_act(tm_act), .in_rec(tm_rec),
      .in_wdata(host_wdata), .dd_in(ide_dd_in),
      .busy(busy), .bus_on(bus_on), .strobe(strobe), .wr_q(wr_q),
      .rdy(host_rdy), .rdata(host_rdata), .dout(ide_dd_out));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ide_chan <= '0;
         ide_a    <= '0;
         ctl_q    <= 1'b0;
      end else if (start) begin
         ide_chan <= dec_chan;
         ide_a    <= dec_off;
         ctl_q    <= dec_ctl;
      end
   end

   assign ide_cs0_n  = !(bus_on && !ctl_q);
   assign ide_cs1_n  = !(bus_on && ctl_q);
   assign ide_dior_n = !(strobe && !wr_q);
   assign ide_diow_n = !(strobe && wr_q);
   assign ide_dd_oe  = bus_on && wr_q;

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      ide_dior_n || ide_diow_n); // R10
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ide_dior_n && ide_diow_n) && $past(!(ide_dior_n && ide_diow_n)))
      |-> ($stable(ide_a) && $stable(ide_chan))); // R10
   AST_CS_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ide_dior_n && ide_diow_n) |-> (ide_cs0_n ^ ide_cs1_n)); // R9
   AST_UNCLAIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_claim && !busy)
      |=> (ide_dior_n && ide_diow_n && !host_rdy)); // R2
endmodule

// File: tb/ide_pio_timer_tb_top.sv
module ide_pio_timer_tb_top;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic        cs0_n;
      logic        cs1_n;
      logic [2:0]  a;
      logic [1:0]  ch;
      logic        dior_n;
      logic        diow_n;
      logic        oe;
      logic [15:0] dout;
      logic        rdy;
   } ev_t;

   localparam ev_t IDLE_EV = '{cs0_n: 1'b1, cs1_n: 1'b1, a: 3'd0, ch: 2'd0,
                               dior_n: 1'b1, diow_n: 1'b1, oe: 1'b0,
                               dout: 16'h0, rdy: 1'b0};
   localparam logic [15:0] BB [4] = '{16'h01F0, 16'h0170, 16'h01E8, 16'h0168};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_req = 1'b0, host_wr = 1'b0, host_wide = 1'b0;
   logic [15:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic host_claim, host_rdy;
   logic [31:0] host_rdata;
   logic [3:0] base_en = 4'b0111;
   logic [7:0] drv_tsel = 8'b0000_1000;
   logic [1:0][3:0] set_setup = {4'd1, 4'd2};
   logic [1:0][3:0] set_rdlen = {4'd5, 4'd3};
   logic [1:0][3:0] set_wrlen = {4'd4, 4'd2};
   logic [1:0][3:0] set_recov = {4'd3, 4'd2};
   logic [1:0] ide_chan;
   logic ide_cs0_n, ide_cs1_n, ide_dior_n, ide_diow_n, ide_dd_oe;
   logic [2:0] ide_a;
   logic [15:0] ide_dd_out, ide_dd_in;

   int n_cmp = 0, n_bad = 0, cyc = 0, rd_cnt = 0, nrd = 0;
   logic prev_dior = 1'b1;
   logic dev_m [4] = '{1'b0, 1'b0, 1'b0, 1'b0};
   logic [31:0] exp_rdata = '0;
   string cur_tag = "reset";
   ev_t q[$];

   assign ide_dd_in = 16'hA000 + 16'(rd_cnt);

   always #(CLK_PERIOD / 2) clk = ~clk;

   ide_pio_timer dut_i (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
      .host_wide(host_wide), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_claim(host_claim), .host_rdy(host_rdy), .host_rdata(host_rdata),
      .base_en(base_en), .drv_tsel(drv_tsel), .set_setup(set_setup),
      .set_rdlen(set_rdlen), .set_wrlen(set_wrlen), .set_recov(set_recov),
      .ide_chan(ide_chan), .ide_cs0_n(ide_cs0_n), .ide_cs1_n(ide_cs1_n),
      .ide_a(ide_a), .ide_dior_n(ide_dior_n), .ide_diow_n(ide_diow_n),
      .ide_dd_out(ide_dd_out), .ide_dd_oe(ide_dd_oe), .ide_dd_in(ide_dd_in));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL [%s] %s act=%h exp=%h", cur_tag, what, act, exp);
      end
   endtask

   task automatic tick();
      ev_t e;
      @(negedge clk);
      e = (q.size() > 0) ? q.pop_front() : IDLE_EV;
      chk(32'(ide_cs0_n), 32'(e.cs0_n), "R9 cs0_n");
      chk(32'(ide_cs1_n), 32'(e.cs1_n), "R9 cs1_n");
      if (!e.cs0_n || !e.cs1_n) begin
         chk(32'(ide_a), 32'(e.a), "R9 ide_a");
         chk(32'(ide_chan), 32'(e.ch), "R9 ide_chan");
      end
      chk(32'(ide_dior_n), 32'(e.dior_n), "R4 dior_n");
      chk(32'(ide_diow_n), 32'(e.diow_n), "R4 diow_n");
      chk(32'(ide_dd_oe), 32'(e.oe), "R6 dd_oe");
      if (e.oe) chk(32'(ide_dd_out), 32'(e.dout), "R5 dd_out");
      chk(32'(host_rdy), 32'(e.rdy), "R8 host_rdy");
      if (e.rdy) chk(host_rdata, exp_rdata, "R6 host_rdata");
      chk(32'(ide_dior_n || ide_diow_n), 32'd1, "R10 strobe exclusive");
      if (!prev_dior && ide_dior_n) rd_cnt++;
      prev_dior = ide_dior_n;
   endtask

   function automatic int max1(input logic [3:0] v);
      return (v == 4'd0) ? 1 : int'(v);
   endfunction

   task automatic access(input logic wr, input logic wide, input logic [15:0] ad,
                         input logic [31:0] wd, input logic exp_claim, input string tag);
      logic ctl, split, is8, sel;
      int ch, s, a, r;
      ev_t e;
      logic [31:0] erd;
      cur_tag = tag;
      ctl = 1'b0;
      ch = 0;
      for (int i = 3; i >= 0; i--) begin
         if (base_en[i] && ad[15:3] == BB[i][15:3]) begin ch = i; ctl = 1'b0; end
         if (base_en[i] && ad == BB[i] + 16'h0206) begin ch = i; ctl = 1'b1; end
      end
      host_req = 1'b1; host_wr = wr; host_wide = wide;
      host_addr = ad; host_wdata = wd;
      #1;
      chk(32'(host_claim), 32'(exp_claim), "R1/R2/R3 claim");
      if (exp_claim) begin
         sel   = drv_tsel[ch * 2 + int'(dev_m[ch])];
         s     = max1(set_setup[sel]);
         a     = max1(wr ? set_wrlen[sel] : set_rdlen[sel]);
         r     = max1(set_recov[sel]);
         split = !ctl && ad[2:0] == 3'd0 && wide;
         is8   = ctl || ad[2:0] != 3'd0;
         if (wr && !ctl && ad[2:0] == 3'd6) dev_m[ch] = wd[4];
         erd = '0;
         e = '{cs0_n: ctl, cs1_n: !ctl, a: ad[2:0], ch: 2'(ch), dior_n: 1'b1,
               diow_n: 1'b1, oe: wr, dout: wd[15:0], rdy: 1'b0};
         repeat (s) q.push_back(e);
         for (int w = 0; w < (split ? 2 : 1); w++) begin
            e.dout = (w == 1) ? wd[31:16] : wd[15:0];
            e.dior_n = wr; e.diow_n = !wr;
            repeat (a) q.push_back(e);
            if (!wr) begin
               if (w == 1) erd[31:16] = 16'hA000 + 16'(nrd);
               else if (is8) erd[7:0] = 8'(16'hA000 + 16'(nrd));
               else erd[15:0] = 16'hA000 + 16'(nrd);
               nrd++;
            end
            e.dior_n = 1'b1; e.diow_n = 1'b1;
            repeat (r) q.push_back(e);
         end
         exp_rdata = erd;
         e = IDLE_EV; e.rdy = 1'b1;
         q.push_back(e);
      end
      tick();
      host_req = 1'b0;
      while (q.size() > 0) tick();
      tick();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_bad++;
         $display("FAIL watchdog R8 act=%0d exp=<20000 cycles", cyc);
         summary();
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick(); tick();
      access(1'b0, 1'b0, 16'h01F0, 32'h0,         1'b1, "R4 read 16-bit set0");
      access(1'b1, 1'b1, 16'h01F0, 32'h1234ABCD,  1'b1, "R5 write 32-bit split");
      access(1'b0, 1'b1, 16'h01F0, 32'h0,         1'b1, "R5 read 32-bit split");
      access(1'b1, 1'b0, 16'h0176, 32'h00000010,  1'b1, "R7 select dev1 on ch1");
      access(1'b0, 1'b0, 16'h0171, 32'h0,         1'b1, "R7 set1 byte read");
      access(1'b1, 1'b0, 16'h01F3, 32'h00000055,  1'b1, "R6 byte write");
      access(1'b0, 1'b0, 16'h03EE, 32'h0,         1'b1, "R9 control read ch2");
      access(1'b0, 1'b0, 16'h03F7, 32'h0,         1'b0, "R3 shared reg ch0");
      access(1'b1, 1'b0, 16'h0377, 32'h0,         1'b0, "R3 shared reg ch1");
      access(1'b0, 1'b0, 16'h0168, 32'h0,         1'b0, "R2 disabled ch3");
      access(1'b0, 1'b0, 16'h0200, 32'h0,         1'b0, "R2 no match");
      base_en = 4'b1111;
      access(1'b0, 1'b0, 16'h0168, 32'h0,         1'b1, "R1 ch3 enabled");
      set_setup[1] = 4'd0; set_rdlen[1] = 4'd0; set_recov[1] = 4'd0;
      access(1'b0, 1'b0, 16'h0170, 32'h0,         1'b1, "R4 zero counts clamp");
      access(1'b1, 1'b0, 16'h0176, 32'h00000000,  1'b1, "R7 select dev0 on ch1");
      access(1'b0, 1'b1, 16'h0170, 32'h0,         1'b1, "R7 back to set0 split");
      summary();
   end
endmodule